// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared optical front end. On the transmit side it watches the UART's serial output and turns every zero bit into one short light pulse. Ones, including idle time and stop bits, send no light. On the receive side it watches the front end's output. When it sees a pulse edge, it rebuilds a zero bit of normal NRZ width for the UART receiver. All timing comes from the UART's 16X oversampling tick, a one-clock strobe that fires sixteen times per bit.

A mode input picks the pulse width. The slow setting gives pulses 3/16 of a bit wide. The fast setting gives pulses a quarter of a bit wide. A polarity input lets the block work with front ends whose receive output idles high. When the enable input is low, the light output is held off and the recovered line is held at the idle level.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset, `ir_tx` is low and `rx_nrz` is high.
- R2: With `fast_mode`=0, each zero bit on `tx_nrz` gives exactly one `ir_tx` pulse, 3 ticks wide. The pulse starts when the bit phase reaches 7, counting phase 0 as the tick that samples the bit. `ir_tx` rises one clock after that tick.
- R3: With `fast_mode`=1, each zero bit gives one pulse, 4 ticks wide, starting at bit phase 6.
- R4: A one bit on `tx_nrz`, including an idle line, produces no pulse.
- R5: Whenever a tick samples a new level on `tx_nrz`, the bit phase resets to 0. Otherwise the phase wraps every 16 ticks, so a run of zero bits gives one pulse per bit.
- R6: While `enable` is low, `ir_tx` stays low and `rx_nrz` stays high, whatever is on `tx_nrz` and `ir_rx`.
- R7: The decoder samples `ir_rx` XOR `rx_invert` at each tick. It treats a 0-to-1 change between two consecutive samples as a pulse edge. `rx_nrz` goes low one clock after the tick that follows the sampling tick, which adds one tick of delay.
- R8: After a pulse edge, `rx_nrz` stays low for 16 ticks and then returns high. A new edge during that time restarts the count, so pulses 16 ticks apart give one continuous low.
- R9: With `rx_invert`=1, a low-going pulse on an idle-high `ir_rx` decodes the same way that a high-going pulse does with `rx_invert`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16X oversampling strobe, one clock wide |
| enable | input | 1 | 1 = infrared mode active |
| fast_mode | input | 1 | 0 = 3/16-bit pulses, 1 = 1/4-bit pulses |
| rx_invert | input | 1 | 1 = `ir_rx` idles high and its pulses are low-going |
| tx_nrz | input | 1 | UART serial output (NRZ, idle high) |
| ir_tx | output | 1 | Infrared transmit pulse, active high |
| ir_rx | input | 1 | Infrared receive input from the front end |
| rx_nrz | output | 1 | Recovered NRZ stream for the UART receiver |

## Verification
The encoder gets four kinds of input: a single start bit, an all-zero byte, an alternating byte, and an idle line. These separate the per-bit pulse count, the phase wrap between zero bits that come back to back, and the absence of light for ones. The width and the starting offset of the first pulse are measured in both modes, so the 3-tick and 4-tick windows and their start phases are each checked. The decoder gets a single pulse and a train of three pulses in each polarity. The single pulse checks the one-tick delay and the 16-tick low time. The train checks that a new edge restarts the low count. Finally, the enable input is dropped while stimulus is still applied on both sides.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;
  localparam int unsigned DEF_BIT_TICKS = 16;

  // pulse width in ticks for the chosen mode
  function automatic int unsigned pulse_len(input logic fast, input int unsigned bit_ticks);
    return fast ? bit_ticks / 4 : (3 * bit_ticks) / 16;
  endfunction

  // bit phase at which the pulse begins
  function automatic int unsigned pulse_start(input logic fast, input int unsigned bit_ticks);
    return fast ? (bit_ticks - bit_ticks / 4) / 2 : (7 * bit_ticks) / 16;
  endfunction
endpackage

// File: rtl/irda_sir_enc.sv
module irda_sir_enc
  import irda_sir_pkg::*;
#(
  parameter int unsigned BIT_TICKS = DEF_BIT_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic fast_mode,
  input  logic tx_nrz,
  output logic ir_tx
);
  localparam int unsigned PW = $clog2(BIT_TICKS);
  localparam logic [PW:0] SLOW_ST  = (PW+1)'(pulse_start(1'b0, BIT_TICKS));
  localparam logic [PW:0] FAST_ST  = (PW+1)'(pulse_start(1'b1, BIT_TICKS));
  localparam logic [PW:0] SLOW_END = (PW+1)'(pulse_start(1'b0, BIT_TICKS) + pulse_len(1'b0, BIT_TICKS));
  localparam logic [PW:0] FAST_END = (PW+1)'(pulse_start(1'b1, BIT_TICKS) + pulse_len(1'b1, BIT_TICKS));
  localparam logic [PW-1:0] LAST_PH = PW'(BIT_TICKS - 1);
  localparam int unsigned LEN_MAX = pulse_len(1'b1, BIT_TICKS);

  logic          bit_q;
  logic [PW-1:0] phase;
  logic          level_change;
  logic          in_window;
  logic [PW:0]   win_st, win_end;

  assign level_change = tick && (tx_nrz != bit_q);
  assign win_st  = fast_mode ? FAST_ST  : SLOW_ST;
  assign win_end = fast_mode ? FAST_END : SLOW_END;
  assign in_window = ({1'b0, phase} >= win_st) && ({1'b0, phase} < win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b1;
      phase <= '0;
    end else if (tick) begin
      bit_q <= tx_nrz;
      if (level_change || phase == LAST_PH) phase <= '0;
      else                                  phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_tx <= 1'b0;
    else        ir_tx <= enable && !bit_q && in_window;
  end

  // checker state: ticks seen while the pulse is lit
  logic [PW:0] lit_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lit_ticks <= '0;
    else if (!ir_tx) lit_ticks <= '0;
    else if (tick)   lit_ticks <= lit_ticks + 1'b1;
  end

  p_width_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lit_ticks) <= int'(LEN_MAX));
  p_one_is_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_q) |-> !ir_tx);
  p_dark_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ir_tx);
  p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> !$past(bit_q));
endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec
  import irda_sir_pkg::*;
#(
  parameter int unsigned BIT_TICKS = DEF_BIT_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic rx_invert,
  input  logic ir_rx,
  output logic rx_nrz
);
  localparam int unsigned CW = $clog2(BIT_TICKS + 1);
  localparam logic [CW-1:0] LOW_TICKS = CW'(BIT_TICKS);

  logic          samp, prev;
  logic [CW-1:0] low_cnt;
  logic          edge_seen;

  assign edge_seen = enable && tick && samp && !prev;
  assign rx_nrz    = (low_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp    <= 1'b0;
      prev    <= 1'b0;
      low_cnt <= '0;
    end else if (!enable) begin
      samp    <= 1'b0;
      prev    <= 1'b0;
      low_cnt <= '0;
    end else if (tick) begin
      samp <= ir_rx ^ rx_invert;
      prev <= samp;
      if (edge_seen)           low_cnt <= LOW_TICKS;
      else if (low_cnt != '0)  low_cnt <= low_cnt - 1'b1;
    end
  end

  p_fall_needs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_nrz) |-> $past(edge_seen));
  p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_nrz) |-> ($past(tick) || !$past(enable)));
  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rx_nrz);
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
  import irda_sir_pkg::*;
#(
  parameter int unsigned BIT_TICKS = DEF_BIT_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic fast_mode,
  input  logic rx_invert,
  input  logic tx_nrz,
  output logic ir_tx,
  input  logic ir_rx,
  output logic rx_nrz
);
  irda_sir_enc #(.BIT_TICKS(BIT_TICKS)) u_enc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .fast_mode(fast_mode), .tx_nrz(tx_nrz), .ir_tx(ir_tx)
  );

  irda_sir_dec #(.BIT_TICKS(BIT_TICKS)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .rx_invert(rx_invert), .ir_rx(ir_rx), .rx_nrz(rx_nrz)
  );

  // R1: outputs at their idle levels whenever reset is held
  always_comb begin
    if (!rst_n) p_reset_idle_r1: assert (!ir_tx && rx_nrz);
  end
endmodule

// File: tb/irda_sir_codec_test.sv
module irda_sir_codec_test;
  localparam int T = 4;      // clocks per tick
  localparam int BT = 16;    // ticks per bit
  localparam int BITCLK = T * BT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fast_mode = 1'b0, rx_invert = 1'b0;
  logic tx_nrz = 1'b1, ir_rx = 1'b0;
  logic ir_tx, rx_nrz;
  logic [1:0] div = 2'd0;
  logic tick;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign tick = (div == 2'd3);

  irda_sir_codec uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .fast_mode(fast_mode), .rx_invert(rx_invert), .tx_nrz(tx_nrz),
    .ir_tx(ir_tx), .ir_rx(ir_rx), .rx_nrz(rx_nrz)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic align();
    do @(negedge clk); while (div != 2'd0);
  endtask

  // send bits LSB first, then idle two bits; measure ir_tx
  task automatic t_tx(input bit fast, input logic [15:0] bits, input int n,
                      input int exp_pulses, input string req);
    int pulses = 0, hi = 0, first = -1, clk_i = 0;
    logic last = 1'b0;
    int plen = fast ? BT / 4 : (3 * BT) / 16;
    int pst  = fast ? (BT - BT / 4) / 2 : (7 * BT) / 16;
    fast_mode = fast;
    align();
    for (int b = 0; b < n + 2; b++) begin
      tx_nrz = (b < n) ? bits[b] : 1'b1;
      for (int c = 0; c < BITCLK; c++) begin
        @(negedge clk);
        clk_i++;
        if (ir_tx && !last) begin
          pulses++;
          if (first < 0) first = clk_i;
        end
        if (ir_tx) hi++;
        last = ir_tx;
      end
    end
    check(pulses == exp_pulses, {req, " pulse count"}, pulses, exp_pulses);
    check(hi == exp_pulses * plen * T, {req, " lit clocks"}, hi, exp_pulses * plen * T);
    if (exp_pulses > 0)
      check(first == T * (pst + 1) + 1, {req, " first pulse offset"}, first, T * (pst + 1) + 1);
  endtask

  // send pulses one bit apart, measure rx_nrz
  task automatic t_rx(input bit inv, input int npulses, input int exp_fall,
                      input int exp_low, input string req);
    int falls = 0, low = 0, first = -1, clk_i = 0;
    logic last = 1'b1;
    rx_invert = inv;
    ir_rx = inv;
    align();
    for (int b = 0; b < npulses + 2; b++) begin
      for (int c = 0; c < BITCLK; c++) begin
        ir_rx = (b < npulses && c < 3 * T) ? ~inv : inv;
        @(negedge clk);
        clk_i++;
        if (!rx_nrz && last) begin
          falls++;
          if (first < 0) first = clk_i;
        end
        if (!rx_nrz) low++;
        last = rx_nrz;
      end
    end
    check(falls == (exp_low > 0 ? 1 : 0), {req, " fall count"}, falls, exp_low > 0 ? 1 : 0);
    check(low == exp_low, {req, " low clocks"}, low, exp_low);
    if (exp_low > 0) check(first == exp_fall, {req, " fall offset"}, first, exp_fall);
    ir_rx = 1'b0;
    rx_invert = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ir_tx == 1'b0, "R1 ir_tx", ir_tx, 0);
    check(rx_nrz == 1'b1, "R1 rx_nrz", rx_nrz, 1);
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    t_tx(1'b0, 16'h0000, 9, 0, "R6 tx off");
    t_rx(1'b0, 1, 0, 0, "R6 rx off");
    enable = 1'b1;
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    t_tx(1'b0, 16'h0000, 1, 1, "R2 slow start bit");
    t_tx(1'b1, 16'h0000, 1, 1, "R3 fast start bit");
    t_tx(1'b0, 16'h0200, 10, 9, "R5 zero byte slow");
    t_tx(1'b1, 16'h02AA, 10, 5, "R4 alt byte fast");
    t_tx(1'b0, 16'hFFFF, 4, 0, "R4 idle line");
    t_rx(1'b0, 1, 2 * T, BITCLK, "R7 single pulse");
    t_rx(1'b0, 3, 2 * T, 3 * BITCLK, "R8 pulse train");
    t_rx(1'b1, 1, 2 * T, BITCLK, "R9 inverted single");
    t_rx(1'b1, 3, 2 * T, 3 * BITCLK, "R9 inverted train");
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * T);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule